// File: doc/BRIEF.md
# Peripheral Chip Select Generator

This block decodes a 20-bit bus address into active-low chip selects for a peripheral block of seven 256-byte windows. The windows sit one after another above a programmable base. Window positions 0, 1, 2, 3, 5 and 6 each drive a select. Position 4 takes up address space but never drives a select. The whole block can live in the 1-Mbyte memory space or in the 64-Kbyte I/O space, and only accesses of the chosen kind can hit it.

A select goes low in the same cycle as the address strobe, so it follows address-phase timing. It stays low until the cycle after the bus reports the end of the cycle. On each strobe a wait counter loads the wait count of the window that was hit, and a ready output stays low while waits remain. The four low windows take a 3-bit wait code with an extended, non-linear upper half. The two high windows use only the low two bits of their code. A small write port loads two registers. Register 0 holds the base, the space selector and the bus width. Register 1 holds the six wait codes. The block takes no accesses until register 0 has been written.

Top module: `pcs_decode_top`

## Requirements
- R1: After reset every select output is high, `rdy` is high and `bus_wide` is 0. Until register 0 (`cfg_addr`=0) is written, no strobe asserts a select, whatever its address.
- R2: Register 0 holds `cfg_wdata[11:0]` as the base, which is address bits 19:8. A strobe whose address lies in [base*256 + n*256, base*256 + n*256 + 255] drives `pcs_n[n]` low for n in {0,1,2,3,5,6}. Window 4 drives no select, and `pcs_n[4]` is always high.
- R3: A strobe below the base or at or above base*256 + 1792 asserts no select.
- R4: `cfg_wdata[12]` in register 0 picks the space: 0 for memory, 1 for I/O. A strobe whose `bus_is_io` differs from that bit asserts no select. In I/O mode, an address with any of bits 19:16 set asserts no select.
- R5: A select goes low in the strobe cycle itself. It stays low without a new strobe until `cyc_done` is seen, and it is high in the cycle after that.
- R6: Register 1 holds 3-bit wait codes in these fields: window 0 at bits 2:0, window 1 at 5:3, window 2 at 8:6, window 3 at 11:9. In windows 0 to 3, codes 0 to 7 give 0, 1, 2, 3, 5, 7, 9 and 15 waits. `rdy` is low for exactly that many cycles, starting in the cycle after the strobe.
- R7: The codes for windows 5 (bits 14:12) and 6 (bits 17:15) use only their low two bits, which give 0 to 3 waits.
- R8: `bus_wide` shows `cfg_wdata[13]` from the last write to register 0 (1 means 16-bit).
- R9: A new strobe reloads the wait counter and the held select, even while waits from an earlier cycle remain.
- R10: A strobe that hits no select, including one into window 4, leaves `rdy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register index (0 base/space/width, 1 wait codes) |
| cfg_wdata | input | 18 | Register write data |
| as_strobe | input | 1 | Address strobe, one cycle per bus cycle |
| bus_addr | input | 20 | Bus address, valid with the strobe |
| bus_is_io | input | 1 | 1 for an I/O access, 0 for memory |
| cyc_done | input | 1 | End of the current bus cycle |
| pcs_n | output | 7 | Active-low selects indexed by window (bit 4 unused, high) |
| rdy | output | 1 | Low while wait cycles remain |
| bus_wide | output | 1 | Configured width of the select range, 1 = 16-bit |

## Verification
On every cycle the assertions check four things: at most one select is ever low, and nothing asserts before configuration or on a wrong-space access. A held select stays put between strobes and is released after `cyc_done`. A running wait count steps down by one each cycle. Other behaviour can only be shown by the bench's directed scenarios, since it needs reference values worked out from the programmed registers. This covers each window's exact address bounds and the dark window 4. It also covers the non-linear wait table, the two-bit truncation in the upper group, the reload of a count in progress and the I/O upper-bit qualification.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned CNT_W  = 4;

  // Wait cycles for a 3-bit wait code: linear low half, extended upper half.
  function automatic logic [CNT_W-1:0] wait_of(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] w;
    case (code)
      3'd4:    w = 4'd5;
      3'd5:    w = 4'd7;
      3'd6:    w = 4'd9;
      3'd7:    w = 4'd15;
      default: w = {1'b0, code};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs #(
  parameter int unsigned BASE_W    = 12,
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned HOLE_SLOT = 4,
  parameter int unsigned CFG_DW    = 18,
  localparam int unsigned CW       = pcs_pkg::CODE_W
) (
  input  logic                      clk,
  input  logic                      rst_sync_n,
  input  logic                      cfg_we,
  input  logic                      cfg_addr,
  input  logic [CFG_DW-1:0]         cfg_wdata,
  output logic [BASE_W-1:0]         base_q,
  output logic                      space_io_q,
  output logic                      wide_q,
  output logic                      enabled_q,
  output logic [NUM_SLOTS*CW-1:0]   codes_q
);
  logic                    wr_main;
  logic                    wr_wait;
  logic [BASE_W-1:0]       base_d;
  logic                    space_io_d;
  logic                    wide_d;
  logic                    enabled_d;
  logic [NUM_SLOTS*CW-1:0] codes_d;
  logic [NUM_SLOTS*CW-1:0] codes_wr;

  assign wr_main = cfg_we && !cfg_addr;
  assign wr_wait = cfg_we &&  cfg_addr;

  // Packed wait fields skip the dark window, so field k maps to slot k or k+1.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_field
    if (s == HOLE_SLOT) begin : g_dark
      assign codes_wr[s*CW +: CW] = '0;
    end else if (s < HOLE_SLOT) begin : g_below
      assign codes_wr[s*CW +: CW] = cfg_wdata[s*CW +: CW];
    end else begin : g_above
      assign codes_wr[s*CW +: CW] = cfg_wdata[(s-1)*CW +: CW];
    end
  end

  if (CFG_DW > BASE_W + 2) begin : g_spare
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_wdata[CFG_DW-1:BASE_W+2];
  end

  always_comb begin
    base_d     = base_q;
    space_io_d = space_io_q;
    wide_d     = wide_q;
    enabled_d  = enabled_q;
    codes_d    = codes_q;
    if (wr_main) begin
      base_d     = cfg_wdata[BASE_W-1:0];
      space_io_d = cfg_wdata[BASE_W];
      wide_d     = cfg_wdata[BASE_W+1];
      enabled_d  = 1'b1;
    end
    if (wr_wait) begin
      codes_d = codes_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q     <= '0;
      space_io_q <= 1'b0;
      wide_q     <= 1'b0;
      enabled_q  <= 1'b0;
      codes_q    <= '0;
    end else begin
      base_q     <= base_d;
      space_io_q <= space_io_d;
      wide_q     <= wide_d;
      enabled_q  <= enabled_d;
      codes_q    <= codes_d;
    end
  end
endmodule

// File: rtl/pcs_addr_match.sv
module pcs_addr_match #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned WIN_SHIFT = 8,
  parameter int unsigned IO_ADDR_W = 16,
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned HOLE_SLOT = 4,
  localparam int unsigned BASE_W   = ADDR_W - WIN_SHIFT
) (
  input  logic                 as_strobe,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_is_io,
  input  logic [BASE_W-1:0]    base_q,
  input  logic                 space_io_q,
  input  logic                 enabled_q,
  output logic [NUM_SLOTS-1:0] hit_vec
);
  logic [BASE_W:0]   diff;
  logic              no_borrow;
  logic              in_block;
  logic              space_ok;
  logic              io_range_ok;
  logic              qualify;
  logic              unused_addr_low;

  // Window index = page number minus base, without wrap past the top.
  assign diff      = {1'b0, bus_addr[ADDR_W-1:WIN_SHIFT]} - {1'b0, base_q};
  assign no_borrow = !diff[BASE_W];
  assign in_block  = no_borrow && (diff[BASE_W-1:0] < BASE_W'(NUM_SLOTS));

  assign space_ok    = (bus_is_io == space_io_q);
  assign io_range_ok = !space_io_q || (bus_addr[ADDR_W-1:IO_ADDR_W] == '0);
  assign qualify     = as_strobe && enabled_q && space_ok && io_range_ok && in_block;

  assign unused_addr_low = ^bus_addr[WIN_SHIFT-1:0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    if (s == HOLE_SLOT) begin : g_dark
      assign hit_vec[s] = 1'b0;
    end else begin : g_live
      assign hit_vec[s] = qualify && (diff[BASE_W-1:0] == BASE_W'(s));
    end
  end
endmodule

// File: rtl/pcs_wait_ctr.sv
module pcs_wait_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             rdy
);
  logic [CNT_W-1:0] cnt_d;
  logic             dec_en;

  assign dec_en = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec_en) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign rdy = (cnt_q == '0);
endmodule

// File: rtl/pcs_decode_top.sv
module pcs_decode_top #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned WIN_SHIFT = 8,
  parameter int unsigned IO_ADDR_W = 16,
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned HOLE_SLOT = 4,
  parameter int unsigned LOW_GROUP = 4,
  localparam int unsigned BASE_W   = ADDR_W - WIN_SHIFT,
  localparam int unsigned CW       = pcs_pkg::CODE_W,
  localparam int unsigned WAIT_DW  = (NUM_SLOTS - 1) * CW,
  localparam int unsigned CFG_DW   = (WAIT_DW > BASE_W + 2) ? WAIT_DW : BASE_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  input  logic                 as_strobe,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_is_io,
  input  logic                 cyc_done,
  output logic [NUM_SLOTS-1:0] pcs_n,
  output logic                 rdy,
  output logic                 bus_wide
);
  localparam int unsigned CNT_W = pcs_pkg::CNT_W;

  logic                    rst_sync_n;
  logic [BASE_W-1:0]       base_q;
  logic                    space_io_q;
  logic                    wide_q;
  logic                    enabled_q;
  logic [NUM_SLOTS*CW-1:0] codes_q;
  logic [NUM_SLOTS-1:0]    hit_vec;
  logic [NUM_SLOTS-1:0]    hold_q;
  logic [NUM_SLOTS-1:0]    hold_d;
  logic [CNT_W-1:0]        slot_wait [NUM_SLOTS];
  logic [CNT_W-1:0]        load_val;
  logic [CNT_W-1:0]        wait_cnt;

  pcs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcs_cfg_regs #(
    .BASE_W    (BASE_W),
    .NUM_SLOTS (NUM_SLOTS),
    .HOLE_SLOT (HOLE_SLOT),
    .CFG_DW    (CFG_DW)
  ) u_cfg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .base_q     (base_q),
    .space_io_q (space_io_q),
    .wide_q     (wide_q),
    .enabled_q  (enabled_q),
    .codes_q    (codes_q)
  );

  pcs_addr_match #(
    .ADDR_W    (ADDR_W),
    .WIN_SHIFT (WIN_SHIFT),
    .IO_ADDR_W (IO_ADDR_W),
    .NUM_SLOTS (NUM_SLOTS),
    .HOLE_SLOT (HOLE_SLOT)
  ) u_match (
    .as_strobe  (as_strobe),
    .bus_addr   (bus_addr),
    .bus_is_io  (bus_is_io),
    .base_q     (base_q),
    .space_io_q (space_io_q),
    .enabled_q  (enabled_q),
    .hit_vec    (hit_vec)
  );

  // Per-window wait cycles: full table below LOW_GROUP, two-bit code above.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_wait
    if (s == HOLE_SLOT) begin : g_dark
      assign slot_wait[s] = '0;
    end else if (s < LOW_GROUP) begin : g_ext
      assign slot_wait[s] = pcs_pkg::wait_of(codes_q[s*CW +: CW]);
    end else begin : g_short
      assign slot_wait[s] = pcs_pkg::wait_of({1'b0, codes_q[s*CW +: 2]});
    end
  end

  always_comb begin
    load_val = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (hit_vec[s]) load_val = load_val | slot_wait[s];
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (as_strobe) begin
      hold_d = hit_vec;
    end else if (cyc_done) begin
      hold_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  pcs_wait_ctr #(
    .CNT_W (CNT_W)
  ) u_wait (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .load       (as_strobe),
    .load_val   (load_val),
    .cnt_q      (wait_cnt),
    .rdy        (rdy)
  );

  assign pcs_n    = ~(as_strobe ? hit_vec : hold_q);
  assign bus_wide = wide_q;
endmodule

// File: rtl/pcs_decode_chk.sv
module pcs_decode_chk #(
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 as_strobe,
  input logic                 bus_is_io,
  input logic                 cyc_done,
  input logic [NUM_SLOTS-1:0] pcs_n,
  input logic                 rdy,
  input logic                 space_io_q,
  input logic                 enabled_q,
  input logic [CNT_W-1:0]     wait_cnt
);
  // R2: at most one window selected at any time
  p_single_select_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(~pcs_n));

  // R1: nothing asserts and no waits before the main register is written
  p_quiet_unconfigured_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enabled_q |-> ((&pcs_n) && rdy));

  // R4: an access of the other space never selects
  p_space_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (as_strobe && (bus_is_io != space_io_q)) |-> (&pcs_n));

  // R5: held select does not move between strobes
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!as_strobe && !cyc_done) |=> (!as_strobe -> $stable(pcs_n)));

  // R5: select released after the cycle ends
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc_done && !as_strobe) |=> (!as_strobe -> (&pcs_n)));

  // R6: a running wait count steps down by one per cycle
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wait_cnt != '0 && !as_strobe) |=> (wait_cnt == $past(wait_cnt) - 1'b1));
endmodule

bind pcs_decode_top pcs_decode_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .CNT_W     (pcs_pkg::CNT_W)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .as_strobe  (as_strobe),
  .bus_is_io  (bus_is_io),
  .cyc_done   (cyc_done),
  .pcs_n      (pcs_n),
  .rdy        (rdy),
  .space_io_q (space_io_q),
  .enabled_q  (enabled_q),
  .wait_cnt   (wait_cnt)
);

// File: tb/pcs_decode_top_tb_top.sv
`timescale 1ns/1ps
module pcs_decode_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_addr;
  logic [17:0] cfg_wdata;
  logic        as_strobe;
  logic [19:0] bus_addr;
  logic        bus_is_io;
  logic        cyc_done;
  logic [6:0]  pcs_n;
  logic        rdy;
  logic        bus_wide;

  int n_checks = 0;
  int n_fails  = 0;

  pcs_decode_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .as_strobe (as_strobe),
    .bus_addr  (bus_addr),
    .bus_is_io (bus_is_io),
    .cyc_done  (cyc_done),
    .pcs_n     (pcs_n),
    .rdy       (rdy),
    .bus_wide  (bus_wide)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_waits(input int slot, input int code);
    int c;
    c = (slot >= 4) ? (code & 3) : code;
    case (c)
      4: return 5;
      5: return 7;
      6: return 9;
      7: return 15;
      default: return c;
    endcase
  endfunction

  function automatic logic [6:0] ref_sel(input int slot);
    if (slot < 0 || slot == 4) return 7'h7f;
    return ~(7'h01 << slot);
  endfunction

  task automatic cfg_write(input bit a, input logic [17:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One full bus cycle: select in strobe cycle, waits, then cycle end.
  task automatic bus_cycle(input logic [19:0] a, input bit io, input int slot,
                           input int waits, input string req);
    int cnt;
    @(negedge clk);
    as_strobe = 1'b1; bus_addr = a; bus_is_io = io;
    #1;
    check(pcs_n == ref_sel(slot), req, "select in strobe cycle", pcs_n, ref_sel(slot));
    @(negedge clk);
    as_strobe = 1'b0;
    #1;
    check(pcs_n == ref_sel(slot), "R5", "select held after strobe", pcs_n, ref_sel(slot));
    cnt = 0;
    while (!rdy && cnt < 40) begin
      cnt++;
      @(negedge clk); #1;
    end
    check(cnt == waits, req, "wait cycles", cnt, waits);
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
    #1;
    check(pcs_n == 7'h7f, "R5", "release after cycle end", pcs_n, 7'h7f);
  endtask

  task automatic t_reset;
    #1;
    check(pcs_n == 7'h7f, "R1", "reset selects", pcs_n, 7'h7f);
    check(rdy == 1'b1, "R1", "reset rdy", rdy, 1);
    check(bus_wide == 1'b0, "R8", "reset width", bus_wide, 0);
    bus_cycle(20'h00000, 1'b0, -1, 0, "R1");
  endtask

  localparam logic [17:0] CODES_A = 18'(7 | (4 << 3) | (5 << 6) | (6 << 9) | (7 << 12) | (6 << 15));
  localparam logic [17:0] CODES_B = 18'(0 | (1 << 3) | (2 << 6) | (3 << 9) | (1 << 12) | (0 << 15));
  localparam int CA [7] = '{7, 4, 5, 6, 0, 7, 6};
  localparam int CB [7] = '{0, 1, 2, 3, 0, 1, 0};

  task automatic t_memory_windows;
    cfg_write(1'b0, 18'h120 | (18'd1 << 13));
    #1;
    check(bus_wide == 1'b1, "R8", "width after write", bus_wide, 1);
    cfg_write(1'b1, CODES_A);
    for (int s = 0; s < 7; s++) begin
      bus_cycle(20'h12000 + 20'(s * 256) + 20'h80, 1'b0, (s == 4) ? -1 : s,
                (s == 4) ? 0 : ref_waits(s, CA[s]), (s == 4) ? "R10" : ((s >= 5) ? "R7" : "R6"));
    end
    bus_cycle(20'h12000, 1'b0, 0, ref_waits(0, CA[0]), "R2");
    bus_cycle(20'h126FF, 1'b0, 6, ref_waits(6, CA[6]), "R2");
  endtask

  task automatic t_outside;
    bus_cycle(20'h11FFF, 1'b0, -1, 0, "R3");
    bus_cycle(20'h12700, 1'b0, -1, 0, "R3");
    bus_cycle(20'h12100, 1'b1, -1, 0, "R4");
  endtask

  task automatic t_io_space;
    cfg_write(1'b0, 18'h040 | (18'd1 << 12));
    #1;
    check(bus_wide == 1'b0, "R8", "width cleared", bus_wide, 0);
    cfg_write(1'b1, CODES_B);
    for (int s = 0; s < 4; s++)
      bus_cycle(20'h04000 + 20'(s * 256), 1'b1, s, ref_waits(s, CB[s]), "R6");
    bus_cycle(20'h04500, 1'b1, 5, ref_waits(5, CB[5]), "R7");
    bus_cycle(20'h04100, 1'b0, -1, 0, "R4");
    bus_cycle(20'h14100, 1'b1, -1, 0, "R4");
  endtask

  task automatic t_reload;
    int cnt;
    cfg_write(1'b0, 18'h120);
    cfg_write(1'b1, CODES_A);
    @(negedge clk);
    as_strobe = 1'b1; bus_addr = 20'h12010; bus_is_io = 1'b0;
    @(negedge clk);
    as_strobe = 1'b0;
    repeat (3) @(negedge clk);
    as_strobe = 1'b1; bus_addr = 20'h12510;
    #1;
    check(pcs_n == ref_sel(5), "R9", "reload select", pcs_n, ref_sel(5));
    @(negedge clk);
    as_strobe = 1'b0;
    #1;
    cnt = 0;
    while (!rdy && cnt < 40) begin
      cnt++;
      @(negedge clk); #1;
    end
    check(cnt == ref_waits(5, CA[5]), "R9", "reloaded waits", cnt, ref_waits(5, CA[5]));
    check(pcs_n == ref_sel(5), "R9", "reloaded hold", pcs_n, ref_sel(5));
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    as_strobe = 1'b0; bus_addr = '0; bus_is_io = 1'b0; cyc_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_memory_windows();
    t_outside();
    t_io_space();
    t_reload();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule